// File: doc/BRIEF.md
# Grouped Single/Multi-Key Touch Arbiter

This block sits between a touch-sensing front end and whatever consumes key states. Once per scan it takes the raw per-key detect vector for sixteen keys and reduces it to the set of keys that may be reported. A two-bit mode option selects the policy. In single-key behaviour a group reports at most one key. In multi-key behaviour a group reports every touched key.

The sixteen keys form either one group or two fixed groups. The two groups are interleaved nibbles: group A holds keys 0-3 and 8-11, and group B holds keys 4-7 and 12-15. When a single-key group has several touched keys, the key with the lowest index wins. Signal strength plays no part. An eight-key select confines the block to keys 0-7.

The result is latched on a scan strobe and held between strobes. Every strobe picks the winners again from the current raw inputs, so the block keeps no history of earlier winners.

Top module: `touch_key_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `keys_out` is all zeros.
- R2: `keys_out` takes a new value only in the cycle after a cycle with `scan_stb` high, and holds its value otherwise, whatever `raw_keys` does.
- R3: With `mode_sel` = 2'b00, all sixteen keys form one multi-key group, and `keys_out` equals the (masked) `raw_keys` sampled on the strobe.
- R4: With `mode_sel` = 2'b11, all sixteen keys form one single-key group, and only the lowest-indexed touched key is reported.
- R5: Group A is bits 0-3 and 8-11, and group B is bits 4-7 and 12-15. Bit i belongs to group A when (i/4) is even.
- R6: With `mode_sel` = 2'b10, groups A and B are each single-key. Each group reports only its own lowest-indexed touched key.
- R7: With `mode_sel` = 2'b01, group A is single-key (lowest index wins) and group B is multi-key (all touched keys reported).
- R8: With `eight_key_mode` = 1, bits 8-15 of `keys_out` are always 0, and touches on keys 8-15 take no part in arbitration.
- R9: Winners are chosen from scratch on every strobe. When the previous winner is released, the lowest-indexed key still touched is reported after the next strobe.
- R10: `keys_out` never reports a key that was not touched in `raw_keys` on the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_keys | input | 16 | Raw touch detect per key, bit i = key i touched |
| mode_sel | input | 2 | Arbitration mode: 00 all multi, 01 A single/B multi, 10 both single, 11 all single |
| eight_key_mode | input | 1 | 1 = only keys 0-7 in use |
| scan_stb | input | 1 | Scan strobe: latch the arbitrated vector |
| keys_out | output | 16 | Arbitrated key states, bit i = key i reported |

## Verification
The block's only state is the output register, so a wrong latch condition shows as `keys_out` changing, or failing to change, one cycle after the strobe cycle. A wrong group map or a wrong priority direction shows in the cycle after a single strobe. The tests apply several touched keys spread across both nibbles of each group. Such a pattern makes a swapped group, a highest-index winner or a missed eight-key mask visible in the reported bits.

// File: rtl/key_arb_pkg.sv
package key_arb_pkg;
   typedef enum logic [1:0] {
      ARB_ALL_MULTI    = 2'b00,
      ARB_SPLIT_MIXED  = 2'b01,
      ARB_SPLIT_SINGLE = 2'b10,
      ARB_ALL_SINGLE   = 2'b11
   } arb_mode_e;
endpackage

// File: rtl/key_group_map.sv
module key_group_map #(
   parameter int NUM_KEYS = 16,
   parameter int NIBBLE   = 4
) (
   output logic [NUM_KEYS-1:0] grp_a_o,
   output logic [NUM_KEYS-1:0] low_half_o
);
   localparam int HALF = NUM_KEYS / 2;

   for (genvar i = 0; i < NUM_KEYS; i++) begin : g_bit
      // interleaved nibbles: even nibble index -> group A
      assign grp_a_o[i]    = (((i / NIBBLE) % 2) == 0);
      assign low_half_o[i] = (i < HALF);
   end
endmodule

// File: rtl/lowest_key_pick.sv
module lowest_key_pick #(
   parameter int WIDTH      = 16,
   parameter bit ARITH_PICK = 1'b1
) (
   input  logic [WIDTH-1:0] cand_i,
   output logic [WIDTH-1:0] pick_o
);
   if (ARITH_PICK) begin : g_arith
      // two's complement isolates the lowest set bit
      assign pick_o = cand_i & (~cand_i + WIDTH'(1));
   end else begin : g_chain
      logic [WIDTH:0] seen;
      assign seen[0] = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign pick_o[i]   = cand_i[i] & ~seen[i];
         assign seen[i+1]   = seen[i] | cand_i[i];
      end
   end

   always_comb begin
      assert ($onehot0(pick_o)) else $error("picker produced several bits");
   end
endmodule

// File: rtl/touch_key_arbiter.sv
module touch_key_arbiter
   import key_arb_pkg::*;
#(
   parameter int NUM_KEYS   = 16,
   parameter int NIBBLE     = 4,
   parameter bit ARITH_PICK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] raw_keys,
   input  logic [1:0]          mode_sel,
   input  logic                eight_key_mode,
   input  logic                scan_stb,
   output logic [NUM_KEYS-1:0] keys_out
);
   localparam int GRP_SPAN = 2 * NIBBLE;

   if (NIBBLE < 1) begin : g_bad_nib
      $error("NIBBLE must be at least 1");
   end
   if ((NUM_KEYS % GRP_SPAN) != 0) begin : g_bad_keys
      $error("NUM_KEYS must be a multiple of 2*NIBBLE");
   end

   logic [NUM_KEYS-1:0] grp_a, low_half;
   logic [NUM_KEYS-1:0] masked, cand_a, cand_b;
   logic [NUM_KEYS-1:0] pick_all, pick_a, pick_b;
   logic [NUM_KEYS-1:0] next_keys;

   key_group_map #(.NUM_KEYS(NUM_KEYS), .NIBBLE(NIBBLE)) u_map (
      .grp_a_o    (grp_a),
      .low_half_o (low_half)
   );

   assign masked = raw_keys & (eight_key_mode ? low_half : {NUM_KEYS{1'b1}});
   assign cand_a = masked & grp_a;
   assign cand_b = masked & ~grp_a;

   lowest_key_pick #(.WIDTH(NUM_KEYS), .ARITH_PICK(ARITH_PICK)) u_pick_all (
      .cand_i (masked), .pick_o (pick_all));
   lowest_key_pick #(.WIDTH(NUM_KEYS), .ARITH_PICK(ARITH_PICK)) u_pick_a (
      .cand_i (cand_a), .pick_o (pick_a));
   lowest_key_pick #(.WIDTH(NUM_KEYS), .ARITH_PICK(ARITH_PICK)) u_pick_b (
      .cand_i (cand_b), .pick_o (pick_b));

   always_comb begin
      unique case (arb_mode_e'(mode_sel))
         ARB_ALL_SINGLE:   next_keys = pick_all;
         ARB_SPLIT_SINGLE: next_keys = pick_a | pick_b;
         ARB_SPLIT_MIXED:  next_keys = pick_a | cand_b;
         default:          next_keys = masked;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        keys_out <= '0;
      else if (scan_stb) keys_out <= next_keys;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) !rst_n |=> keys_out == '0);

   // R2
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_stb |=> $stable(keys_out));

   // R10
   only_touched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_stb |=> (keys_out & ~$past(raw_keys)) == '0);

   // R8
   upper_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_stb && eight_key_mode) |=> (keys_out & ~low_half) == '0);

   // R4
   one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_stb && mode_sel == 2'b11) |=> $onehot0(keys_out));

   // R6
   per_group_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_stb && mode_sel == 2'b10) |=>
         ($onehot0(keys_out & grp_a) && $onehot0(keys_out & ~grp_a)));

   // R7
   group_a_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_stb && mode_sel == 2'b01) |=> $onehot0(keys_out & grp_a));

   // R3
   multi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_stb && mode_sel == 2'b00 && !eight_key_mode) |=> keys_out == $past(raw_keys));
endmodule

// File: tb/touch_key_arbiter_tb.sv
`timescale 1ns/1ps
module touch_key_arbiter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] raw_keys;
   logic [1:0]  mode_sel;
   logic        eight_key_mode;
   logic        scan_stb;
   logic [15:0] keys_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   touch_key_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .raw_keys(raw_keys), .mode_sel(mode_sel),
      .eight_key_mode(eight_key_mode), .scan_stb(scan_stb), .keys_out(keys_out));

   function automatic bit in_a(int i);
      return ((i / 4) % 2) == 0;
   endfunction

   function automatic logic [15:0] expect_keys(logic [15:0] raw, logic [1:0] md, logic ek);
      logic [15:0] m, r;
      bit single_a, single_b, got_a, got_b;
      m = ek ? (raw & 16'h00FF) : raw;
      r = '0;
      single_a = (md != 2'b00);
      single_b = (md == 2'b10) || (md == 2'b11);
      got_a = 0; got_b = 0;
      for (int i = 0; i < 16; i++) begin
         if (m[i]) begin
            if (md == 2'b11) begin
               if (!got_a && !got_b) r[i] = 1'b1;
               got_a = 1; got_b = 1;
            end else if (in_a(i)) begin
               if (!single_a || !got_a) r[i] = 1'b1;
               got_a = 1;
            end else begin
               if (!single_b || !got_b) r[i] = 1'b1;
               got_b = 1;
            end
         end
      end
      return r;
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: keys_out=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic scan(string req, logic [15:0] raw, logic [1:0] md, logic ek);
      @(negedge clk);
      raw_keys = raw; mode_sel = md; eight_key_mode = ek; scan_stb = 1'b1;
      @(negedge clk);
      scan_stb = 1'b0;
      check(req, keys_out, expect_keys(raw, md, ek));
   endtask

   task automatic t_reset();
      rst_n = 1'b0; scan_stb = 1'b0; raw_keys = 16'hFFFF; mode_sel = 2'b00; eight_key_mode = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 in reset", keys_out, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", keys_out, 16'h0000);
   endtask

   task automatic t_multi();
      scan("R3 multi", 16'hA5C3, 2'b00, 1'b0);
      scan("R3 multi all", 16'hFFFF, 2'b00, 1'b0);
   endtask

   task automatic t_all_single();
      scan("R4 single", 16'hA5C8, 2'b11, 1'b0);
      check("R4 lowest is key3", keys_out, 16'h0008);
      scan("R4 high only", 16'h8000, 2'b11, 1'b0);
      scan("R4 none", 16'h0000, 2'b11, 1'b0);
   endtask

   task automatic t_split_single();
      // key 9 (group A) and key 5 (group B), with 13 and 11 also touched
      scan("R6 split single", 16'h2A20, 2'b10, 1'b0);
      check("R5 R6 winners 5 and 9", keys_out, 16'h0220);
      scan("R5 high nibbles", 16'hF0F0 & 16'hF000 | 16'h0F00, 2'b10, 1'b0);
      check("R5 key8 and key12", keys_out, 16'h1100);
   endtask

   task automatic t_split_mixed();
      scan("R7 mixed", 16'hF3FC, 2'b01, 1'b0);
      check("R7 A=key2, B all", keys_out, 16'hF0F4);
   endtask

   task automatic t_eight();
      scan("R8 upper only", 16'hF000, 2'b11, 1'b1);
      check("R8 no report", keys_out, 16'h0000);
      scan("R8 multi", 16'hFF81, 2'b00, 1'b1);
      check("R8 multi low only", keys_out, 16'h0081);
      scan("R8 split", 16'h0140, 2'b10, 1'b1);
   endtask

   task automatic t_hold();
      scan("R2 load", 16'h0010, 2'b00, 1'b0);
      @(negedge clk);
      raw_keys = 16'hFFFF; mode_sel = 2'b11;
      repeat (4) @(negedge clk);
      check("R2 held", keys_out, 16'h0010);
   endtask

   task automatic t_takeover();
      scan("R9 first", 16'h0106, 2'b11, 1'b0);
      check("R9 key1 wins", keys_out, 16'h0002);
      scan("R9 release", 16'h0104, 2'b11, 1'b0);
      check("R9 key2 takes over", keys_out, 16'h0004);
      scan("R10 release all", 16'h0000, 2'b01, 1'b0);
   endtask

   initial begin
      t_reset();
      t_multi();
      t_all_single();
      t_split_single();
      t_split_mixed();
      t_eight();
      t_hold();
      t_takeover();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule